// File: doc/BRIEF.md
# Configurable Sub-Pixel Trigger Tree

This block turns four sub-pixel first-photon flags into one pixel trigger. Each sub-pixel raises its flag on the first photon it detects. The block holds each flag for the rest of the acquisition. It feeds the four held flags into a fixed two-level gate tree. In that tree, two first-level nodes each combine one pair of sub-pixels, and a top node combines the two pair results. Each node works as either an AND or an OR. The choice at each node is set by a 2-bit threshold mode. This gives probabilistic thresholds of one, at least two, at least three or at least four photons.

A higher threshold cuts the dead time caused by dark counts, but it gives worse timing resolution. The acquisition sequencer drives two inputs into the block. A ready indication tells the block when it may take a new threshold mode. A clear pulse, issued during recharge, empties the held flags and re-arms the trigger. The trigger output is a single-cycle pulse. Once it has fired, it stays silent until the next clear.

Top module: `subpix_trig_tree`

## Requirements
- R1: A sub-pixel flag (`sub_hit[i]`) that is high at a clock edge is held until a clear. Flags arriving in different cycles therefore combine as if they had arrived together.
- R2: In mode 0 (`mode_in` = 2'd0), all three nodes are OR. The trigger fires when any held flag is set.
- R3: In mode 1 (2'd1), both pair nodes are OR and the top node is AND. The trigger fires when (bit0 | bit1) & (bit2 | bit3).
- R4: In mode 2 (2'd2), the pair node for bits 0 and 1 is AND, the pair node for bits 2 and 3 is OR, and the top node is AND. The trigger fires when (bit0 & bit1) & (bit2 | bit3).
- R5: In mode 3 (2'd3), all three nodes are AND. The trigger fires only when all four held flags are set.
- R6: `pix_trig` is high for exactly one cycle. It rises one clock after the edge at which the tree result first becomes true. For a flag sampled at edge k, that is the cycle after edge k+1.
- R7: After a pulse, `pix_trig` stays low until a clear, even if further flags arrive. After a clear, a new pulse is possible.
- R8: `clear` empties all held flags, and a flag present at the same edge is dropped. No pulse is issued in the cycle after a clear edge.
- R9: `mode_in` is taken only at an edge where `seq_ready` is high. At any other edge, a change of `mode_in` has no effect on the trigger.
- R10: After synchronous reset, `pix_trig` is low, no flags are held, and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_hit | input | 4 | First-photon flags, one per sub-pixel |
| mode_in | input | 2 | Threshold mode request |
| seq_ready | input | 1 | Sequencer is in its ready state; mode may be taken |
| clear | input | 1 | Acquisition clear from the sequencer |
| pix_trig | output | 1 | Registered single-cycle pixel trigger |

## Verification
The bench builds the block with its default four-leaf tree and 2-bit mode. Each of the four modes is paired with each of the sixteen flag patterns. This makes the 64-entry decision table fully reachable, and the bench computes the expected result from the node equations. Further directed sequences check that staggered flags accumulate, that the pulse is masked after it fires, that a flag coinciding with clear is dropped, and that a mode change outside the ready state is ignored.

// File: rtl/sptt_pkg.sv
package sptt_pkg;
  localparam int SUB_N  = 4;
  localparam int PAIR_N = SUB_N / 2;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    THR_ONE   = 2'd0,
    THR_TWO   = 2'd1,
    THR_THREE = 2'd2,
    THR_FOUR  = 2'd3
  } thr_mode_e;

  // Node selects: 1 = AND, 0 = OR
  typedef struct packed {
    logic top_and;
    logic pair_hi_and;
    logic pair_lo_and;
  } node_cfg_t;

  function automatic node_cfg_t decode_mode(thr_mode_e m);
    node_cfg_t c;
    case (m)
      THR_ONE:   c = '{top_and: 1'b0, pair_hi_and: 1'b0, pair_lo_and: 1'b0};
      THR_TWO:   c = '{top_and: 1'b1, pair_hi_and: 1'b0, pair_lo_and: 1'b0};
      THR_THREE: c = '{top_and: 1'b1, pair_hi_and: 1'b0, pair_lo_and: 1'b1};
      default:   c = '{top_and: 1'b1, pair_hi_and: 1'b1, pair_lo_and: 1'b1};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sptt_hit_latch.sv
module sptt_hit_latch #(
  parameter int N = sptt_pkg::SUB_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [N-1:0] hit_in,
  output logic [N-1:0] hit_q
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) hit_q[i] <= 1'b0;
      else if (hit_in[i]) hit_q[i] <= 1'b1;
    end

    // R1
    sticky_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (hit_q[i] && !clear) |=> hit_q[i]);
  end

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (hit_q == '0));
endmodule

// File: rtl/sptt_mode_reg.sv
module sptt_mode_reg
  import sptt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_ready,
  input  logic [MODE_W-1:0] mode_in,
  output node_cfg_t         cfg
);
  thr_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= THR_ONE;
    else if (seq_ready) mode_q <= thr_mode_e'(mode_in);
  end

  assign cfg = decode_mode(mode_q);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_ready |=> $stable(mode_q));
endmodule

// File: rtl/sptt_gate_tree.sv
module sptt_gate_tree
  import sptt_pkg::*;
(
  input  logic [SUB_N-1:0] hits,
  input  node_cfg_t        cfg,
  output logic             tree_res
);
  logic [PAIR_N-1:0] pair_and;
  logic [PAIR_N-1:0] pair_res;

  assign pair_and = {cfg.pair_hi_and, cfg.pair_lo_and};

  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    assign pair_res[p] = pair_and[p] ? (hits[2*p] & hits[2*p+1])
                                     : (hits[2*p] | hits[2*p+1]);
  end

  assign tree_res = cfg.top_and ? (&pair_res) : (|pair_res);
endmodule

// File: rtl/sptt_pulse_gen.sv
module sptt_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic level,
  output logic pulse
);
  logic fired_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fired_q <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= level && !fired_q;
      if (level) fired_q <= 1'b1;
    end
  end

  // R6
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R7
  masked_chk: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !clear) |=> !pulse);
endmodule

// File: rtl/subpix_trig_tree.sv
module subpix_trig_tree
  import sptt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SUB_N-1:0]  sub_hit,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              seq_ready,
  input  logic              clear,
  output logic              pix_trig
);
  logic [SUB_N-1:0] hit_q;
  node_cfg_t        cfg;
  logic             tree_res;

  sptt_hit_latch #(.N(SUB_N)) u_latch (
    .clk(clk), .rst(rst), .clear(clear), .hit_in(sub_hit), .hit_q(hit_q)
  );

  sptt_mode_reg u_mode (
    .clk(clk), .rst(rst), .seq_ready(seq_ready), .mode_in(mode_in), .cfg(cfg)
  );

  sptt_gate_tree u_tree (
    .hits(hit_q), .cfg(cfg), .tree_res(tree_res)
  );

  sptt_pulse_gen u_pulse (
    .clk(clk), .rst(rst), .clear(clear), .level(tree_res), .pulse(pix_trig)
  );

  // R8
  no_trig_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !pix_trig);

  // R2
  any_hit_or_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg == node_cfg_t'(3'b000) && hit_q != '0) |-> tree_res);

  // R5
  all_and_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg == node_cfg_t'(3'b111) && tree_res) |-> (&hit_q));
endmodule

// File: tb/subpix_trig_tree_bench.sv
module subpix_trig_tree_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sub_hit = '0;
  logic [1:0] mode_in = '0;
  logic       seq_ready = 1'b0;
  logic       clear = 1'b0;
  logic       pix_trig;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  subpix_trig_tree u_subpix_trig_tree (
    .clk(clk), .rst(rst), .sub_hit(sub_hit), .mode_in(mode_in),
    .seq_ready(seq_ready), .clear(clear), .pix_trig(pix_trig)
  );

  function automatic bit expect_trig(int m, logic [3:0] h);
    case (m)
      0: return |h;
      1: return (h[0] | h[1]) & (h[2] | h[3]);
      2: return (h[0] & h[1]) & (h[2] | h[3]);
      default: return &h;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_mode(int m);
    @(negedge clk); mode_in = m[1:0]; seq_ready = 1'b1;
    @(negedge clk); seq_ready = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  // Drive one pattern for one edge, then sample four cycles of pix_trig.
  task automatic pulse_and_watch(logic [3:0] p, output logic [3:0] seen);
    @(negedge clk); sub_hit = p;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sub_hit = '0; seen[k] = pix_trig;
    end
  endtask

  initial begin
    logic [3:0] seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state, mode 0 active
    check("R10", {3'b0, pix_trig}, 4'b0);
    pulse_and_watch(4'b0000, seen);
    check("R10", seen, 4'b0000);
    pulse_and_watch(4'b0100, seen);
    check("R10", seen, 4'b0010);
    do_clear();

    // R2 R3 R4 R5 R6: exhaustive mode x pattern
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int p = 0; p < 16; p++) begin
        do_clear();
        pulse_and_watch(p[3:0], seen);
        case (m)
          0: check("R2",  seen, expect_trig(m, p[3:0]) ? 4'b0010 : 4'b0000);
          1: check("R3",  seen, expect_trig(m, p[3:0]) ? 4'b0010 : 4'b0000);
          2: check("R4",  seen, expect_trig(m, p[3:0]) ? 4'b0010 : 4'b0000);
          default: check("R5", seen, expect_trig(m, p[3:0]) ? 4'b0010 : 4'b0000);
        endcase
      end
    end

    // R1: staggered flags accumulate in mode 3
    set_mode(3);
    do_clear();
    pulse_and_watch(4'b0001, seen); check("R1", seen, 4'b0000);
    pulse_and_watch(4'b0010, seen); check("R1", seen, 4'b0000);
    pulse_and_watch(4'b0100, seen); check("R1", seen, 4'b0000);
    pulse_and_watch(4'b1000, seen); check("R6", seen, 4'b0010);

    // R7: masked after firing, re-armed by clear
    pulse_and_watch(4'b1111, seen); check("R7", seen, 4'b0000);
    set_mode(0);
    pulse_and_watch(4'b0001, seen); check("R7", seen, 4'b0000);
    do_clear();
    pulse_and_watch(4'b0001, seen); check("R7", seen, 4'b0010);

    // R8: flag coincident with clear is dropped
    do_clear();
    @(negedge clk); sub_hit = 4'b1111; clear = 1'b1;
    @(negedge clk); sub_hit = '0; clear = 1'b0;
    seen = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); seen[k] = pix_trig;
    end
    check("R8", seen, 4'b0000);
    // R8: clear edge while tree already true suppresses pulse
    @(negedge clk); sub_hit = 4'b0001;
    @(negedge clk); sub_hit = '0; clear = 1'b1;
    @(negedge clk); clear = 1'b0; seen[0] = pix_trig;
    @(negedge clk); seen[1] = pix_trig;
    check("R8", {2'b0, seen[1:0]}, 4'b0000);

    // R9: mode change without ready is ignored
    set_mode(3);
    @(negedge clk); mode_in = 2'd0;
    do_clear();
    pulse_and_watch(4'b0011, seen); check("R9", seen, 4'b0000);
    set_mode(0);
    do_clear();
    pulse_and_watch(4'b0011, seen); check("R9", seen, 4'b0010);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule